// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Control Unit

This block is the sequencing core of a small accumulator processor. It walks through four instruction-cycle phases: fetch, indirect, execute and interrupt. Inside each phase it keeps a one-hot time step. In every clock cycle it decodes the phase, the step, the opcode and the status inputs into gate enables for the datapath, memory read and write strobes, and an ALU function select. Each output is a sum of products of those terms. There is no microcode store.

The datapath registers (PC, IR, MAR, MBR, AC, SP) and the memory sit outside this block. The surrounding processor holds the opcode, the indirect bit and the flags stable while an instruction runs. It then applies the gate enables on each clock edge. The length of the fetch, indirect and interrupt phases is fixed. In the execute phase the opcode sets the length.

Top module: `hwcu_top`

## Requirements
- R1: While `rst` is high, all gates, both strobes, the ALU select and `phase_o` are low. In the first cycle after `rst` falls the unit is in fetch step 1. A reset taken in the middle of an instruction restarts it in the same way.
- R2: `phase_o` carries the cycle code: 2'b00 fetch, 2'b01 indirect, 2'b10 execute, 2'b11 interrupt. Each new phase starts at step 1.
- R3: Fetch steps 1 to 4 drive the following:
  - step 1: gate 2 (PC to MAR)
  - step 2: gates 0 and 5, memory read, gate 14 (PC to ALU) and ALU select 2'b10 (increment)
  - step 3: gate 4 (MBR to IR) and gate 9 (ALU to AC)
  - step 4: gate 15 (AC to PC)
- R4: Fetch continues with two operand steps:
  - step 5: gate 16 (IR address to MAR)
  - step 6: gates 0 and 5 with memory read

  Fetch is six steps long in total.
- R5: After fetch the next phase is indirect when `ind_i` is 1, and execute when it is 0.
- R6: The indirect phase is two steps long:
  - step 1: gate 8 (MBR to MAR)
  - step 2: gates 0 and 5 with memory read

  Execute follows.
- R7: Execute depends on the opcode:
  - ADD (1), 2 steps: step 1 drives gates 6 and 7 with ALU select 2'b01; step 2 drives gate 9.
  - STORE (2), 2 steps: step 1 drives gate 11; step 2 drives gates 12 and 0 with memory write.
  - LOADI (4), 3 steps: step 1 drives gate 8; step 2 drives gates 0 and 5 with memory read; step 3 drives gates 6 and 9 with ALU select 2'b11 (pass).
  - Every other opcode is one silent step.
- R8: ISZ (3) takes three steps:
  - step 1: gate 6 with ALU select 2'b10
  - step 2: gate 13 (ALU to MBR)
  - step 3: gates 12 and 0 with memory write; gate 10 (PC skip increment) is added only when `zero_i` is 1
- R9: After execute the next phase is interrupt when `irq_i` and `int_en_i` are both 1, and fetch otherwise.
- R10: The interrupt phase is five steps long, and fetch follows it:
  - step 1: gate 1 (PC to MBR) and gate 17 (SP to MAR)
  - step 2: gates 12 and 0 with memory write
  - step 3: gate 18 (vector code to MAR)
  - step 4: gates 5 and 0 with memory read
  - step 5: gate 3 (MBR to PC)
- R11: Exactly one time step is active in every cycle. Memory read and memory write are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | OP_W (4) | Opcode field of the current instruction |
| ind_i | input | 1 | Indirect bit of the current instruction |
| irq_i | input | 1 | Interrupt request pending |
| int_en_i | input | 1 | Interrupts enabled |
| zero_i | input | 1 | Zero flag from the datapath |
| gate_o | output | 19 | One-hot-per-path gate enables, bit n = gate Cn |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| alu_sel_o | output | 2 | ALU function: 00 idle, 01 add, 10 increment, 11 pass |
| phase_o | output | 2 | Current cycle code |

## Verification
The bench targets the following corner cases:
- **Phase boundaries.** A unit with a wrong step length would run the next phase's gates one cycle early or late. A unit that missed the next-phase choice would skip the indirect phase, or enter the interrupt phase while interrupts are masked.
- **The ISZ skip.** Gate 10 is checked with the zero flag both set and clear. A flag ignored in the decode shows up as a missing or stray skip.
- **Unknown opcodes.** An unknown opcode must yield a single quiet execute step.
- **Reset in the middle of an instruction.** Outputs must go quiet during reset and resume at fetch step 1 afterwards.
- **Combined path.** An indirect instruction followed by an interrupt exercises every phase in one sequence.

// File: rtl/hwcu_pkg.sv
package hwcu_pkg;

   typedef enum logic [1:0] {
      PH_FETCH = 2'b00,
      PH_INDIR = 2'b01,
      PH_EXEC  = 2'b10,
      PH_INTR  = 2'b11
   } phase_e;

   localparam int NGATE     = 19;
   localparam int FETCH_LEN = 6;
   localparam int INDIR_LEN = 2;
   localparam int INTR_LEN  = 5;

   // gate indices
   localparam int G_MAR_BUS  = 0;
   localparam int G_PC_MBR   = 1;
   localparam int G_PC_MAR   = 2;
   localparam int G_MBR_PC   = 3;
   localparam int G_MBR_IR   = 4;
   localparam int G_BUS_MBR  = 5;
   localparam int G_MBR_ALU  = 6;
   localparam int G_AC_ALU   = 7;
   localparam int G_MBR_MAR  = 8;
   localparam int G_ALU_AC   = 9;
   localparam int G_PC_SKIP  = 10;
   localparam int G_AC_MBR   = 11;
   localparam int G_MBR_BUS  = 12;
   localparam int G_ALU_MBR  = 13;
   localparam int G_PC_ALU   = 14;
   localparam int G_AC_PC    = 15;
   localparam int G_IR_MAR   = 16;
   localparam int G_SP_MAR   = 17;
   localparam int G_VEC_MAR  = 18;

   localparam logic [1:0] ALU_IDLE = 2'b00;
   localparam logic [1:0] ALU_ADD  = 2'b01;
   localparam logic [1:0] ALU_INC  = 2'b10;
   localparam logic [1:0] ALU_PASS = 2'b11;

   localparam int OP_ADD   = 1;
   localparam int OP_STORE = 2;
   localparam int OP_ISZ   = 3;
   localparam int OP_LOADI = 4;

   function automatic int phase_len(phase_e ph, int op);
      case (ph)
         PH_FETCH: return FETCH_LEN;
         PH_INDIR: return INDIR_LEN;
         PH_INTR:  return INTR_LEN;
         default: begin
            case (op)
               OP_ADD, OP_STORE: return 2;
               OP_ISZ, OP_LOADI: return 3;
               default:          return 1;
            endcase
         end
      endcase
   endfunction

endpackage

// File: rtl/hwcu_seq.sv
module hwcu_seq
   import hwcu_pkg::*;
#(
   parameter int OP_W      = 4,
   parameter int MAX_STEPS = 6
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [OP_W-1:0]      opcode_i,
   input  logic                 ind_i,
   input  logic                 irq_i,
   input  logic                 int_en_i,
   output phase_e               phase_o,
   output logic [MAX_STEPS-1:0] step_o
);

   phase_e               ph_q, ph_n;
   logic [MAX_STEPS-1:0] st_q, st_n;
   logic                 last;
   int                   len;

   always_comb begin
      len  = phase_len(ph_q, int'(opcode_i));
      last = st_q[len-1];
   end

   always_comb begin
      ph_n = ph_q;
      if (last) begin
         case (ph_q)
            PH_FETCH: ph_n = ind_i ? PH_INDIR : PH_EXEC;
            PH_INDIR: ph_n = PH_EXEC;
            PH_EXEC:  ph_n = (irq_i && int_en_i) ? PH_INTR : PH_FETCH;
            default:  ph_n = PH_FETCH;
         endcase
      end
   end

   for (genvar k = 0; k < MAX_STEPS; k++) begin : g_step
      if (k == 0) begin : g_first
         assign st_n[k] = last;
      end else begin : g_rest
         assign st_n[k] = !last && st_q[k-1];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q <= PH_FETCH;
         st_q <= MAX_STEPS'(1);
      end else begin
         ph_q <= ph_n;
         st_q <= st_n;
      end
   end

   assign phase_o = ph_q;
   assign step_o  = st_q;

   // R11: one step at a time
   a_r11_step_onehot: assert property (@(posedge clk) disable iff (rst)
      $countones(step_o) == 1);
   // R5: fetch exit choice
   a_r5_fetch_to_indir: assert property (@(posedge clk) disable iff (rst)
      (phase_o == PH_FETCH && step_o[FETCH_LEN-1] && ind_i) |=> (phase_o == PH_INDIR && step_o[0]));
   a_r5_fetch_to_exec: assert property (@(posedge clk) disable iff (rst)
      (phase_o == PH_FETCH && step_o[FETCH_LEN-1] && !ind_i) |=> (phase_o == PH_EXEC && step_o[0]));
   // R6: indirect always leads to execute
   a_r6_indir_exit: assert property (@(posedge clk) disable iff (rst)
      (phase_o == PH_INDIR && step_o[INDIR_LEN-1]) |=> (phase_o == PH_EXEC));
   // R9: masked interrupt never taken
   a_r9_masked: assert property (@(posedge clk) disable iff (rst)
      (phase_o == PH_EXEC && !int_en_i && $past(phase_o) != PH_INTR) |=> (phase_o != PH_INTR || $past(phase_o) == PH_INTR));
   // R10: interrupt returns to fetch
   a_r10_intr_exit: assert property (@(posedge clk) disable iff (rst)
      (phase_o == PH_INTR && step_o[INTR_LEN-1]) |=> (phase_o == PH_FETCH && step_o[0]));

endmodule

// File: rtl/hwcu_decode.sv
module hwcu_decode
   import hwcu_pkg::*;
#(
   parameter int OP_W      = 4,
   parameter int MAX_STEPS = 6
) (
   input  logic                 clk,
   input  logic                 rst,
   input  phase_e               phase_i,
   input  logic [MAX_STEPS-1:0] step_i,
   input  logic [OP_W-1:0]      opcode_i,
   input  logic                 zero_i,
   output logic [NGATE-1:0]     gate_o,
   output logic                 rd_o,
   output logic                 wr_o,
   output logic [1:0]           alu_o
);

   logic f, d, x, q;
   logic o_add, o_st, o_isz, o_ldi;
   logic [5:0] s;

   always_comb begin
      f = (phase_i == PH_FETCH);
      d = (phase_i == PH_INDIR);
      x = (phase_i == PH_EXEC);
      q = (phase_i == PH_INTR);
      o_add = (opcode_i == OP_W'(OP_ADD));
      o_st  = (opcode_i == OP_W'(OP_STORE));
      o_isz = (opcode_i == OP_W'(OP_ISZ));
      o_ldi = (opcode_i == OP_W'(OP_LOADI));
      s = step_i[5:0];
   end

   always_comb begin
      gate_o = '0;
      gate_o[G_MAR_BUS] = (f & (s[1] | s[5])) | (d & s[1]) | (q & (s[1] | s[3]))
                        | (x & ((o_st & s[1]) | (o_isz & s[2]) | (o_ldi & s[1])));
      gate_o[G_PC_MBR]  = q & s[0];
      gate_o[G_PC_MAR]  = f & s[0];
      gate_o[G_MBR_PC]  = q & s[4];
      gate_o[G_MBR_IR]  = f & s[2];
      gate_o[G_BUS_MBR] = (f & (s[1] | s[5])) | (d & s[1]) | (q & s[3]) | (x & o_ldi & s[1]);
      gate_o[G_MBR_ALU] = x & ((o_add & s[0]) | (o_isz & s[0]) | (o_ldi & s[2]));
      gate_o[G_AC_ALU]  = x & o_add & s[0];
      gate_o[G_MBR_MAR] = (d & s[0]) | (x & o_ldi & s[0]);
      gate_o[G_ALU_AC]  = (f & s[2]) | (x & ((o_add & s[1]) | (o_ldi & s[2])));
      gate_o[G_PC_SKIP] = x & o_isz & s[2] & zero_i;
      gate_o[G_AC_MBR]  = x & o_st & s[0];
      gate_o[G_MBR_BUS] = (q & s[1]) | (x & ((o_st & s[1]) | (o_isz & s[2])));
      gate_o[G_ALU_MBR] = x & o_isz & s[1];
      gate_o[G_PC_ALU]  = f & s[1];
      gate_o[G_AC_PC]   = f & s[3];
      gate_o[G_IR_MAR]  = f & s[4];
      gate_o[G_SP_MAR]  = q & s[0];
      gate_o[G_VEC_MAR] = q & s[2];
      rd_o = (f & (s[1] | s[5])) | (d & s[1]) | (q & s[3]) | (x & o_ldi & s[1]);
      wr_o = (q & s[1]) | (x & ((o_st & s[1]) | (o_isz & s[2])));
      alu_o = ALU_IDLE;
      if ((f & s[1]) | (x & o_isz & s[0])) alu_o = ALU_INC;
      else if (x & o_add & s[0])           alu_o = ALU_ADD;
      else if (x & o_ldi & s[2])           alu_o = ALU_PASS;
   end

   // R11: strobes exclusive
   a_r11_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
      !(rd_o && wr_o));
   // R8: skip only with zero flag
   a_r8_skip_needs_zero: assert property (@(posedge clk) disable iff (rst)
      gate_o[G_PC_SKIP] |-> (zero_i && wr_o));
   // R3: memory read during fetch always loads MBR from the bus
   a_r3_rd_loads_mbr: assert property (@(posedge clk) disable iff (rst)
      rd_o |-> gate_o[G_BUS_MBR] && gate_o[G_MAR_BUS]);

endmodule

// File: rtl/hwcu_top.sv
module hwcu_top
   import hwcu_pkg::*;
#(
   parameter int OP_W      = 4,
   parameter int MAX_STEPS = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OP_W-1:0]  opcode_i,
   input  logic             ind_i,
   input  logic             irq_i,
   input  logic             int_en_i,
   input  logic             zero_i,
   output logic [18:0]      gate_o,
   output logic             mem_rd_o,
   output logic             mem_wr_o,
   output logic [1:0]       alu_sel_o,
   output logic [1:0]       phase_o
);

   if (MAX_STEPS < FETCH_LEN) begin : g_bad_steps
      $error("MAX_STEPS must cover the longest phase");
   end
   if (OP_W < 3) begin : g_bad_op
      $error("OP_W must encode all opcodes");
   end

   phase_e               ph;
   logic [MAX_STEPS-1:0] st;
   logic [NGATE-1:0]     g;
   logic                 rd, wr;
   logic [1:0]           alu;

   hwcu_seq #(.OP_W(OP_W), .MAX_STEPS(MAX_STEPS)) u_seq (
      .clk(clk), .rst(rst), .opcode_i(opcode_i), .ind_i(ind_i),
      .irq_i(irq_i), .int_en_i(int_en_i), .phase_o(ph), .step_o(st)
   );

   hwcu_decode #(.OP_W(OP_W), .MAX_STEPS(MAX_STEPS)) u_dec (
      .clk(clk), .rst(rst), .phase_i(ph), .step_i(st), .opcode_i(opcode_i),
      .zero_i(zero_i), .gate_o(g), .rd_o(rd), .wr_o(wr), .alu_o(alu)
   );

   always_comb begin
      gate_o    = rst ? '0 : g;
      mem_rd_o  = rst ? 1'b0 : rd;
      mem_wr_o  = rst ? 1'b0 : wr;
      alu_sel_o = rst ? ALU_IDLE : alu;
      phase_o   = rst ? 2'b00 : ph;
   end

   // R1: quiet outputs during reset
   a_r1_quiet_in_reset: assert property (@(posedge clk)
      rst |-> (gate_o == '0 && !mem_rd_o && !mem_wr_o && alu_sel_o == 2'b00));

endmodule

// File: tb/tb_hwcu_top.sv
module tb_hwcu_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0;
   logic        rst = 1;
   logic [3:0]  opcode = 0;
   logic        ind = 0, irq = 0, ien = 0, zero = 0;
   logic [18:0] gate;
   logic        rd, wr;
   logic [1:0]  alu, phase;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // expected item: {phase, alu, wr, rd, gates}
   logic [24:0] exp_q[$];

   hwcu_top dut (
      .clk(clk), .rst(rst), .opcode_i(opcode), .ind_i(ind), .irq_i(irq),
      .int_en_i(ien), .zero_i(zero), .gate_o(gate), .mem_rd_o(rd),
      .mem_wr_o(wr), .alu_sel_o(alu), .phase_o(phase)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [24:0] mk(logic [1:0] ph, logic [1:0] a, logic w, logic r, logic [18:0] g);
      return {ph, a, w, r, g};
   endfunction

   function automatic logic [18:0] b(int n);
      return 19'(1) << n;
   endfunction

   // expected pattern for phase ph, step k (1-based)
   function automatic logic [24:0] expect_item(logic [1:0] ph, int k, int op, logic z);
      logic [18:0] g = '0;
      logic r = 0, w = 0;
      logic [1:0] a = 2'b00;
      case (ph)
         2'b00: case (k) // R3, R4
            1: g = b(2);
            2: begin g = b(0) | b(5) | b(14); r = 1; a = 2'b10; end
            3: g = b(4) | b(9);
            4: g = b(15);
            5: g = b(16);
            6: begin g = b(0) | b(5); r = 1; end
            default: ;
         endcase
         2'b01: case (k) // R6
            1: g = b(8);
            2: begin g = b(0) | b(5); r = 1; end
            default: ;
         endcase
         2'b11: case (k) // R10
            1: g = b(1) | b(17);
            2: begin g = b(12) | b(0); w = 1; end
            3: g = b(18);
            4: begin g = b(5) | b(0); r = 1; end
            5: g = b(3);
            default: ;
         endcase
         default: case (op) // R7, R8
            1: if (k == 1) begin g = b(6) | b(7); a = 2'b01; end else g = b(9);
            2: if (k == 1) g = b(11); else begin g = b(12) | b(0); w = 1; end
            3: if (k == 1) begin g = b(6); a = 2'b10; end
               else if (k == 2) g = b(13);
               else begin g = b(12) | b(0) | (z ? b(10) : 19'(0)); w = 1; end
            4: if (k == 1) g = b(8);
               else if (k == 2) begin g = b(0) | b(5); r = 1; end
               else begin g = b(6) | b(9); a = 2'b11; end
            default: ;
         endcase
      endcase
      return mk(ph, a, w, r, g);
   endfunction

   function automatic int exec_len(int op);
      if (op == 1 || op == 2) return 2;
      if (op == 3 || op == 4) return 3;
      return 1;
   endfunction

   function automatic string tag_of(logic [1:0] ph, int op);
      if (ph == 2'b00) return "R3/fetch";
      if (ph == 2'b01) return "R6";
      if (ph == 2'b11) return "R10";
      if (op == 3) return "R8";
      return "R7";
   endfunction

   int cur_op = 0;

   // driver: push the expected cycle stream of one instruction, then let it run
   task automatic run_instr(int op, logic i, logic rq, logic en, logic z);
      int n = 0;
      opcode = 4'(op); ind = i; irq = rq; ien = en; zero = z; cur_op = op;
      for (int k = 1; k <= 6; k++) begin exp_q.push_back(expect_item(2'b00, k, op, z)); n++; end
      if (i) // R5
         for (int k = 1; k <= 2; k++) begin exp_q.push_back(expect_item(2'b01, k, op, z)); n++; end
      for (int k = 1; k <= exec_len(op); k++) begin exp_q.push_back(expect_item(2'b10, k, op, z)); n++; end
      if (rq && en) // R9
         for (int k = 1; k <= 5; k++) begin exp_q.push_back(expect_item(2'b11, k, op, z)); n++; end
      repeat (n) @(posedge clk);
      #1;
   endtask

   // monitor: compare design output against the scoreboard queue
   always @(negedge clk) begin
      if (!rst && exp_q.size() > 0 && !done) begin
         logic [24:0] e, act;
         e = exp_q.pop_front();
         act = {phase, alu, wr, rd, gate};
         checks++;
         if (act[24:23] != e[24:23]) begin
            errors++;
            $display("FAIL R2 phase: actual=%b expected=%b", act[24:23], e[24:23]);
         end else if (act != e) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag_of(e[24:23], cur_op), act, e);
         end
         if (rd && wr) begin // R11
            errors++;
            $display("FAIL R11: actual rd=%b wr=%b expected not both", rd, wr);
         end
      end
   end

   task automatic check_quiet(string what);
      checks++;
      if (gate !== '0 || rd !== 0 || wr !== 0 || alu !== 0 || phase !== 0) begin
         errors++;
         $display("FAIL R1 %s: actual=%h expected=0", what, {phase, alu, wr, rd, gate});
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check_quiet("in reset");                // R1
      rst = 0;
      run_instr(1, 0, 0, 0, 0);               // R7 ADD, R5 direct
      run_instr(2, 1, 0, 0, 0);               // R5 indirect, R7 STORE
      run_instr(3, 0, 0, 0, 1);               // R8 skip taken
      run_instr(3, 0, 1, 0, 0);               // R8 no skip, R9 masked
      run_instr(4, 0, 1, 1, 0);               // R7 LOADI, R9/R10 interrupt
      run_instr(0, 1, 1, 1, 0);               // all four phases
      run_instr(9, 0, 0, 1, 0);               // R7 unknown opcode
      // R1: reset in the middle of fetch
      opcode = 1;
      repeat (3) @(posedge clk);
      #1 rst = 1;
      @(posedge clk); #1;
      check_quiet("mid-run reset");
      rst = 0;
      #1;
      checks++;
      if (gate !== b(2) || phase !== 2'b00) begin
         errors++;
         $display("FAIL R1 restart: actual=%h expected=%h", gate, b(2));
      end
      run_instr(1, 0, 0, 0, 0);
      run_instr(2, 0, 1, 1, 0);               // R9 interrupt after STORE
      @(posedge clk);
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 5000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end
endmodule